// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the fetch address of a simple in-order processor. It holds a 32-bit program counter and, on every clock, chooses the next fetch address from the instruction word in hand. The choices are the plain step to the next word, a relative branch taken on register equality or inequality, a relative branch taken on the floating-point condition flag, an absolute jump inside the current 256 MiB region, a jump that also supplies a return address, and a jump through a register value.

The datapath gives the block the equality result of the two source registers, the floating-point condition flag and the value of the rs register. The block gives back the current PC and the return-address value that the register file writes into register 31 for a jump-and-link. A stall input freezes the counter. An active-low synchronous reset returns it to the start address. Hazards, delay slots and exceptions are handled elsewhere.

Top module: `pc_sequencer`

## Requirements
- R1: On a rising clock edge with `rst_n` low, `pc_out` becomes 0x0040_0000. This holds whatever the other inputs are, including a high `stall`.
- R2: On a rising edge with `rst_n` high and `stall` high, `pc_out` keeps its value. The instruction is ignored.
- R3: An instruction that is not a control transfer moves `pc_out` to `pc_out + 4`. This covers every opcode (bits 31:26) not listed in R4 to R9, and opcode 0 with a funct (bits 5:0) other than 0x08.
- R4: Opcode 0x04 (branch if equal) with `regs_equal` = 1 loads `pc_out + 4 + D`. D is the immediate in bits 15:0, sign-extended and shifted left by two. With `regs_equal` = 0 it loads `pc_out + 4`.
- R5: Opcode 0x05 (branch if not equal) with `regs_equal` = 0 loads `pc_out + 4 + D`. With `regs_equal` = 1 it loads `pc_out + 4`.
- R6: Opcode 0x11 with bits 25:21 = 0x08 is a branch on the floating-point flag. Bit 16 = 1 branches when `fp_cond` = 1, and bit 16 = 0 branches when `fp_cond` = 0. The target is `pc_out + 4 + D`, otherwise `pc_out + 4`. Opcode 0x11 with any other value in bits 25:21 steps by 4.
- R7: Opcode 0x02 (jump) loads {bits 31:28 of `pc_out + 4`, instruction bits 25:0, 2'b00}.
- R8: Opcode 0x03 (jump and link) loads the same target as R7. `link_out` always equals `pc_out + 8`, which is the value written to register 31.
- R9: Opcode 0 with funct 0x08 (jump register) loads `rs_value` unchanged.
- R10: All address arithmetic wraps modulo 2^32. A step from 0xFFFF_FFFC gives 0, and a negative displacement from 0 goes back below 0 without a carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Holds the PC when high |
| instr | input | 32 | Instruction word being decoded |
| regs_equal | input | 1 | 1 when the rs and rt register values are equal |
| fp_cond | input | 1 | Floating-point condition flag |
| rs_value | input | 32 | Value of the rs register, used as the jump-register target |
| pc_out | output | 32 | Current program counter |
| link_out | output | 32 | Return address (PC+8) for register 31 |

## Verification
The only state is the counter, so a wrong next-address choice shows up on `pc_out` one clock after the instruction that caused it. It also shows up on `link_out` in that same cycle, and it stays there because later steps are relative to the bad value. For this reason a behavioural model in the bench is compared on every clock, so that the first wrong cycle is reported together with the requirement of the instruction class that led to it. The directed part covers each branch polarity in both outcomes, backward displacements, a stall that masks a jump, a reset during a stall, and wraparound at the top of the address space. A long mixed run follows, with random stalls and resets.

// File: rtl/pc_seq_pkg.sv
// Package: shared opcode values and the flow classification used by the
// next-PC unit. Assumes the classic 6-bit opcode / 6-bit funct split.
package pc_seq_pkg;

    localparam logic [5:0] OPC_SPECIAL = 6'h00;
    localparam logic [5:0] OPC_JUMP    = 6'h02;
    localparam logic [5:0] OPC_JLINK   = 6'h03;
    localparam logic [5:0] OPC_BR_EQ   = 6'h04;
    localparam logic [5:0] OPC_BR_NE   = 6'h05;
    localparam logic [5:0] OPC_FPU     = 6'h11;
    localparam logic [4:0] FPU_SUB_BR  = 5'h08;
    localparam logic [5:0] FN_JREG     = 6'h08;

    // Kind of next-address source picked for this cycle
    typedef enum logic [1:0] {
        FLOW_SEQ  = 2'd0,
        FLOW_REL  = 2'd1,
        FLOW_ABS  = 2'd2,
        FLOW_REG  = 2'd3
    } flow_e;

endpackage

// File: rtl/pc_flow_decode.sv
// Module: pc_flow_decode
// Classifies the instruction word into one next-address source and resolves
// branch conditions from the equality and floating-point flags.
// Assumes the instruction word is stable for the whole cycle.
module pc_flow_decode
    import pc_seq_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               regs_equal,
    input  logic               fp_cond,
    output flow_e              flow
);

    localparam int OPC_LSB = INSTR_W - 6;

    logic [5:0] opcode;
    logic [5:0] funct;
    logic [4:0] fmt_sel;
    logic       fp_true_sel;
    logic       rel_taken;
    logic       abs_taken;
    logic       reg_taken;

    assign opcode      = instr[INSTR_W-1:OPC_LSB];
    assign funct       = instr[5:0];
    assign fmt_sel     = instr[25:21];
    assign fp_true_sel = instr[16];

    // Resolve which control transfer, if any, this instruction performs
    always_comb begin
        rel_taken = 1'b0;
        abs_taken = 1'b0;
        reg_taken = 1'b0;
        unique case (opcode)
            OPC_BR_EQ:   rel_taken = regs_equal;
            OPC_BR_NE:   rel_taken = ~regs_equal;
            OPC_FPU:     rel_taken = (fmt_sel == FPU_SUB_BR) && (fp_true_sel == fp_cond);
            OPC_JUMP,
            OPC_JLINK:   abs_taken = 1'b1;
            OPC_SPECIAL: reg_taken = (funct == FN_JREG);
            default:     ;
        endcase
    end

    // Encode the single winning source
    always_comb begin
        if (reg_taken)      flow = FLOW_REG;
        else if (abs_taken) flow = FLOW_ABS;
        else if (rel_taken) flow = FLOW_REL;
        else                flow = FLOW_SEQ;
    end

    // At most one transfer kind may be active for any opcode
    always_comb begin
        AST_ONE_SOURCE: assert ($onehot0({rel_taken, abs_taken, reg_taken}) || $isunknown(instr)); // R3
    end

endmodule

// File: rtl/pc_target_calc.sv
// Module: pc_target_calc
// Computes the sequential, relative, absolute and register targets from the
// current PC and selects one by flow kind. Pure combinational logic.
// Assumes XLEN > 28 so that a region field sits above the 28-bit jump span.
module pc_target_calc
    import pc_seq_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int INSTR_W = 32,
    parameter int STEP    = 4
) (
    input  logic [XLEN-1:0]    pc,
    input  logic [INSTR_W-1:0] instr,
    input  logic [XLEN-1:0]    rs_value,
    input  flow_e              flow,
    output logic [XLEN-1:0]    next_pc,
    output logic [XLEN-1:0]    link_addr
);

    localparam int IMM_W    = 16;
    localparam int INDEX_W  = 26;
    localparam int SPAN_W   = INDEX_W + 2;
    localparam int REGION_W = XLEN - SPAN_W;
    localparam int EXT_W    = XLEN - IMM_W - 2;

    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] disp;
    logic [XLEN-1:0] rel_addr;
    logic [XLEN-1:0] abs_addr;

    assign seq_addr  = pc + XLEN'(STEP);
    assign link_addr = pc + XLEN'(2 * STEP);

    // Sign-extended word displacement, scaled to bytes
    assign disp     = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0], 2'b00};
    assign rel_addr = seq_addr + disp;

    // Splice the word index under the region bits of the sequential address
    generate
        if (REGION_W > 0) begin : g_region
            assign abs_addr = {seq_addr[XLEN-1:SPAN_W], instr[INDEX_W-1:0], 2'b00};
        end else begin : g_flat
            assign abs_addr = XLEN'({instr[INDEX_W-1:0], 2'b00});
        end
    endgenerate

    // Pick the target named by the flow kind
    always_comb begin
        unique case (flow)
            FLOW_REL: next_pc = rel_addr;
            FLOW_ABS: next_pc = abs_addr;
            FLOW_REG: next_pc = rs_value;
            default:  next_pc = seq_addr;
        endcase
    end

endmodule

// File: rtl/pc_sequencer.sv
// Module: pc_sequencer (top)
// Holds the program counter and loads the next fetch address each cycle
// unless stalled. Synchronous active-low reset to RESET_PC.
// Assumes hazards, delay slots and exceptions are handled outside.
module pc_sequencer
    import pc_seq_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              INSTR_W  = 32,
    parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall,
    input  logic [INSTR_W-1:0] instr,
    input  logic               regs_equal,
    input  logic               fp_cond,
    input  logic [XLEN-1:0]    rs_value,
    output logic [XLEN-1:0]    pc_out,
    output logic [XLEN-1:0]    link_out
);

    flow_e           flow;
    logic [XLEN-1:0] next_pc;
    logic [XLEN-1:0] pc_q;

    pc_flow_decode #(
        .INSTR_W    (INSTR_W)
    ) decode_i (
        .instr      (instr),
        .regs_equal (regs_equal),
        .fp_cond    (fp_cond),
        .flow       (flow)
    );

    pc_target_calc #(
        .XLEN      (XLEN),
        .INSTR_W   (INSTR_W),
        .STEP      (4)
    ) target_i (
        .pc        (pc_q),
        .instr     (instr),
        .rs_value  (rs_value),
        .flow      (flow),
        .next_pc   (next_pc),
        .link_addr (link_out)
    );

    // Program counter register: reset, hold on stall, else advance
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= RESET_PC;
        else if (!stall) pc_q <= next_pc;
    end

    assign pc_out = pc_q;

    AST_RESET_START: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> pc_q == RESET_PC); // R1

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(pc_q)); // R2

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && flow == FLOW_SEQ) |=> pc_q == $past(pc_q) + XLEN'(4)); // R3

    AST_JUMP_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && flow == FLOW_ABS) |=> pc_q[27:0] == {$past(instr[25:0]), 2'b00}); // R7

    AST_JREG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && flow == FLOW_REG) |=> pc_q == $past(rs_value)); // R9

    AST_LINK_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (link_out - pc_out) == XLEN'(8)); // R8

endmodule

// File: tb/pc_sequencer_tb_top.sv
// Bench: behavioural next-PC model compared on every clock.
module pc_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        stall;
    logic [31:0] instr;
    logic        regs_equal;
    logic        fp_cond;
    logic [31:0] rs_value;
    logic [31:0] pc_out;
    logic [31:0] link_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_pc = 32'h0;

    always #5 clk = ~clk;

    pc_sequencer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall      (stall),
        .instr      (instr),
        .regs_equal (regs_equal),
        .fp_cond    (fp_cond),
        .rs_value   (rs_value),
        .pc_out     (pc_out),
        .link_out   (link_out)
    );

    function automatic logic [31:0] rel_tgt(input logic [31:0] pc, input logic [15:0] imm);
        int signed off;
        off = int'(signed'(imm)) * 4;
        return pc + 32'd4 + 32'(off);
    endfunction

    // Reference next address, with the requirement tag it exercises
    function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic [31:0] ins,
                                             input logic eq, input logic fc, input logic [31:0] rsv,
                                             input logic st, input logic rn, output string tag);
        logic [31:0] nxt;
        nxt = pc + 32'd4;
        tag = "R3";
        if (!rn) begin
            tag = "R1"; return 32'h0040_0000;
        end
        if (st) begin
            tag = "R2"; return pc;
        end
        case (ins[31:26])
            6'd4: begin tag = "R4"; if (eq) nxt = rel_tgt(pc, ins[15:0]); end
            6'd5: begin tag = "R5"; if (!eq) nxt = rel_tgt(pc, ins[15:0]); end
            6'd17: begin
                tag = "R6";
                if (ins[25:21] == 5'd8 && ins[16] == fc) nxt = rel_tgt(pc, ins[15:0]);
            end
            6'd2: begin tag = "R7"; nxt = ((pc + 32'd4) & 32'hF000_0000) | ({6'd0, ins[25:0]} << 2); end
            6'd3: begin tag = "R8"; nxt = ((pc + 32'd4) & 32'hF000_0000) | ({6'd0, ins[25:0]} << 2); end
            6'd0: if (ins[5:0] == 6'd8) begin tag = "R9"; nxt = rsv; end
            default: ;
        endcase
        return nxt;
    endfunction

    // Apply one cycle of inputs, then compare both outputs with the model
    task automatic step(input logic [31:0] ins, input logic eq, input logic fc,
                        input logic [31:0] rsv, input logic st, input logic rn, input string force_tag);
        string tag;
        logic [31:0] exp;
        instr = ins; regs_equal = eq; fp_cond = fc; rs_value = rsv; stall = st; rst_n = rn;
        exp = ref_next(model_pc, ins, eq, fc, rsv, st, rn, tag);
        if (force_tag != "") tag = force_tag;
        @(posedge clk);
        @(negedge clk);
        model_pc = exp;
        checks++;
        if (pc_out !== exp) begin
            errors++;
            $display("FAIL %s pc_out got %h expected %h", tag, pc_out, exp);
        end
        checks++;
        if (link_out !== exp + 32'd8) begin
            errors++;
            $display("FAIL R8 link_out got %h expected %h", link_out, exp + 32'd8);
        end
    endtask

    function automatic logic [31:0] rand_instr();
        logic [31:0] r;
        r = $urandom;
        case ($urandom_range(0, 8))
            0: r[31:26] = 6'd4;
            1: r[31:26] = 6'd5;
            2: begin r[31:26] = 6'd17; if ($urandom_range(0, 3) != 0) r[25:21] = 5'd8; end
            3: r[31:26] = 6'd2;
            4: r[31:26] = 6'd3;
            5: begin r[31:26] = 6'd0; r[5:0] = 6'd8; end
            6: r[31:26] = 6'd0;
            default: if (r[31:26] inside {6'd0, 6'd2, 6'd3, 6'd4, 6'd5, 6'd17}) r[31:26] = 6'h23;
        endcase
        return r;
    endfunction

    localparam logic [31:0] NOP_ALU = 32'h0109_4021;

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stimulus
        instr = '0; regs_equal = 0; fp_cond = 0; rs_value = '0; stall = 0; rst_n = 0;
        @(negedge clk);
        step(NOP_ALU, 0, 0, 0, 0, 0, "R1");
        step(NOP_ALU, 0, 0, 0, 1, 0, "R1");
        step(NOP_ALU, 0, 0, 0, 0, 1, "R3");
        step({6'd4, 10'd0, 16'd3}, 1, 0, 0, 0, 1, "R4");
        step({6'd4, 10'd0, 16'd3}, 0, 0, 0, 0, 1, "R4");
        step({6'd5, 10'd0, 16'hFFFE}, 0, 0, 0, 0, 1, "R5");
        step({6'd5, 10'd0, 16'hFFFE}, 1, 0, 0, 0, 1, "R5");
        step({6'd17, 5'd8, 4'd0, 1'b1, 16'd5}, 0, 1, 0, 0, 1, "R6");
        step({6'd17, 5'd8, 4'd0, 1'b0, 16'd5}, 0, 0, 0, 0, 1, "R6");
        step({6'd17, 5'd8, 4'd0, 1'b1, 16'd5}, 0, 0, 0, 0, 1, "R6");
        step({6'd17, 5'd16, 4'd0, 1'b1, 16'd5}, 0, 1, 0, 0, 1, "R6");
        step({6'd2, 26'h2AB_CDEF}, 0, 0, 0, 0, 1, "R7");
        step({6'd3, 26'h012_3456}, 0, 0, 0, 0, 1, "R8");
        step({6'd2, 26'h3FF_FFFF}, 0, 0, 0, 1, 1, "R2");
        step({6'd0, 20'd0, 6'd8}, 0, 0, 32'h1234_5679, 0, 1, "R9");
        step({6'd0, 20'd0, 6'd8}, 0, 0, 32'hFFFF_FFFC, 0, 1, "R9");
        step(NOP_ALU, 0, 0, 0, 0, 1, "R10");
        step({6'd4, 10'd0, 16'hFFFE}, 1, 0, 0, 0, 1, "R10");
        step({6'd2, 26'h000_0010}, 1, 0, 0, 0, 1, "R7");
        step({6'd2, 26'h000_0010}, 1, 0, 0, 1, 0, "R1");
        for (int i = 0; i < 4000; i++) begin
            step(rand_instr(), 1'($urandom), 1'($urandom), $urandom,
                 $urandom_range(0, 4) == 0, $urandom_range(0, 99) != 0, "");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule